// File: doc/BRIEF.md
# Supply Supervisor Reset and Watchdog Controller

This block is the digital half of a CPU supervisor. Two comparator flags arrive already synchronous to the block clock. One says the main supply is above its trip point. The other says a secondary rail is above its own trip point. From these flags the block produces a system reset in both polarities and a fail flag for the secondary rail. The reset is held for a selectable power-on timeout after the main supply recovers. All timing is counted in pulses of a tick input of known period. The count limits are parameters, and by default they assume a 1 ms tick.

The block also runs a watchdog. The watchdog does not have a kick pin. It is restarted by a pattern seen on the two-wire bus lines. SDA falls while SCL is high, then SCL falls, then SDA rises while SCL is high, which is a stop. If no such pattern arrives within the selected interval, the active-low watchdog output asserts and stays asserted. A three-bit sticky fault register records low-supply events, secondary-rail events and watchdog timeouts until it is cleared by a strobe.

Top module: `supply_supervisor`

## Requirements
- R1: While `supply_ok` is low, `rst_hi` is 1 from the next clock onward.
- R2: After `supply_ok` goes high, reset stays asserted until `supply_ok` has been high for N tick pulses, and then it releases. N is POR_T0, POR_T1, POR_T2 or POR_T3 for `por_sel` codes 0, 1, 2 and 3.
- R3: A single low sample of `supply_ok` during the timeout restarts the count from zero, so a full new timeout is needed.
- R4: `rst_lo_n` is always the complement of `rst_hi`.
- R5: `wdt_sel` codes 0, 1 and 2 select intervals of WDT_T0, WDT_T1 and WDT_T2 ticks. Code 3 disables the watchdog, and `wdt_n` then stays 1.
- R6: If no restart pattern is seen for the selected interval after reset releases or after the last restart, `wdt_n` goes to 0. It stays at 0 until a restart pattern arrives.
- R7: A restart pattern is: SDA falls while SCL is high, then SCL falls, then SDA rises while SCL is high. The pattern clears the watchdog count and sets `wdt_n` to 1. A stop that follows a start with no SCL fall between them is not a restart.
- R8: While reset is asserted, the watchdog count is held at zero and `wdt_n` is 1.
- R9: `aux_fail_n` equals `aux_ok` in the same cycle with no delay, including while reset is asserted.
- R10: `fault_q` bit 0 is set by a low `supply_ok`, bit 1 by a low `aux_ok`, and bit 2 by a watchdog timeout. The bits are sticky. `fault_clr` clears them, but a condition still present in the same cycle sets its bit again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| tick | input | 1 | One-cycle timing pulse of known period |
| supply_ok | input | 1 | Main supply above trip point (synchronous) |
| aux_ok | input | 1 | Secondary rail above trip point (synchronous) |
| sda | input | 1 | Bus data line, asynchronous |
| scl | input | 1 | Bus clock line, asynchronous |
| por_sel | input | 2 | Power-on reset timeout select |
| wdt_sel | input | 2 | Watchdog interval select, code 3 disables |
| fault_clr | input | 1 | Clear strobe for the fault register |
| rst_hi | output | 1 | Active-high system reset |
| rst_lo_n | output | 1 | Active-low system reset |
| wdt_n | output | 1 | Active-low watchdog timeout |
| aux_fail_n | output | 1 | Active-low secondary-rail fail |
| fault_q | output | 3 | Sticky fault bits {watchdog, aux, supply} |

## Verification
The bench measures the release point of the reset for every timeout code, inside a window of two cycles. A design with the wrong limit, or one that counts clock cycles instead of ticks, falls outside that window. It drops the supply for one cycle in the middle of a timeout. A design that only pauses the count would release too early. It sends a start and then a stop with no SCL fall between them. A detector that is too eager would clear a watchdog that has timed out. It also removes the supply while the watchdog output is asserted, to catch a watchdog that is not held during reset. It checks that the fault bits survive after the condition has gone and that the clear strobe removes them.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [1:0] {
        KS_IDLE    = 2'd0,
        KS_START   = 2'd1,
        KS_CLOCKED = 2'd2
    } kick_st_e;

    typedef struct packed {
        logic [1:0] sda_meta;
        logic [1:0] scl_meta;
        logic       sda_prev;
        logic       scl_prev;
        kick_st_e   st;
        logic       kick;
    } bus_regs_t;

    localparam int unsigned FAULT_W   = 3;
    localparam int unsigned FB_SUPPLY = 0;
    localparam int unsigned FB_AUX    = 1;
    localparam int unsigned FB_WDT    = 2;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sup_bus_watch.sv
module sup_bus_watch
    import sup_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sda,
    input  logic scl,
    output logic kick
);

    bus_regs_t r_q, r_d;

    logic sda_s, scl_s;
    logic sda_fall, sda_rise, scl_fall;

    assign sda_s    = r_q.sda_meta[1];
    assign scl_s    = r_q.scl_meta[1];
    assign sda_fall = r_q.sda_prev & ~sda_s;
    assign sda_rise = ~r_q.sda_prev & sda_s;
    assign scl_fall = r_q.scl_prev & ~scl_s;

    always_comb begin
        r_d          = r_q;
        r_d.sda_meta = {r_q.sda_meta[0], sda};
        r_d.scl_meta = {r_q.scl_meta[0], scl};
        r_d.sda_prev = sda_s;
        r_d.scl_prev = scl_s;
        r_d.kick     = 1'b0;
        unique case (r_q.st)
            KS_IDLE: begin
                if (sda_fall && scl_s) r_d.st = KS_START;
            end
            KS_START: begin
                if (sda_rise && scl_s) r_d.st = KS_IDLE;
                else if (scl_fall)     r_d.st = KS_CLOCKED;
            end
            KS_CLOCKED: begin
                if (sda_fall && scl_s) begin
                    r_d.st = KS_START;
                end else if (sda_rise && scl_s) begin
                    r_d.st   = KS_IDLE;
                    r_d.kick = 1'b1;
                end
            end
            default: r_d.st = KS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.sda_meta <= 2'b11;
            r_q.scl_meta <= 2'b11;
            r_q.sda_prev <= 1'b1;
            r_q.scl_prev <= 1'b1;
            r_q.st       <= KS_IDLE;
            r_q.kick     <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign kick = r_q.kick;

    // R7: a restart pulse only follows a start that has seen an SCL fall
    a_r7_kick_after_clocked: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.kick |-> $past(r_q.st) == KS_CLOCKED);

    // R7: a restart always returns the detector to idle
    a_r7_kick_returns_idle: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.kick |-> r_q.st == KS_IDLE);

endmodule

// File: rtl/sup_por.sv
module sup_por
    import sup_pkg::*;
#(
    parameter int unsigned T0 = 50,
    parameter int unsigned T1 = 200,
    parameter int unsigned T2 = 400,
    parameter int unsigned T3 = 800
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       supply_ok,
    input  logic [1:0] sel,
    output logic       active
);

    localparam int unsigned TMAX = max_u(max_u(T0, T1), max_u(T2, T3));
    localparam int unsigned CW   = $clog2(TMAX + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          act;
    } por_regs_t;

    por_regs_t r_q, r_d;
    logic [CW-1:0] lim;

    always_comb begin
        unique case (sel)
            2'd0:    lim = CW'(T0);
            2'd1:    lim = CW'(T1);
            2'd2:    lim = CW'(T2);
            default: lim = CW'(T3);
        endcase
    end

    always_comb begin
        r_d = r_q;
        if (!supply_ok) begin
            r_d.cnt = '0;
            r_d.act = 1'b1;
        end else if (r_q.act && tick) begin
            if (r_q.cnt >= lim - CW'(1)) begin
                r_d.cnt = '0;
                r_d.act = 1'b0;
            end else begin
                r_d.cnt = r_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.cnt <= '0;
            r_q.act <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign active = r_q.act;

    a_r1_assert_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> r_q.act);

    a_r2_release_needs_supply: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.act) |-> $past(supply_ok) && $past(tick));

    a_r3_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> r_q.cnt == '0);

endmodule

// File: rtl/sup_wdt.sv
module sup_wdt
    import sup_pkg::*;
#(
    parameter int unsigned I0 = 25,
    parameter int unsigned I1 = 200,
    parameter int unsigned I2 = 1400
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       hold,
    input  logic       kick,
    input  logic [1:0] sel,
    output logic       bite
);

    localparam int unsigned IMAX = max_u(max_u(I0, I1), I2);
    localparam int unsigned CW   = $clog2(IMAX + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          bite;
    } wdt_regs_t;

    wdt_regs_t r_q, r_d;
    logic [CW-1:0] lim;
    logic          off;

    assign off = (sel == 2'd3);

    always_comb begin
        unique case (sel)
            2'd0:    lim = CW'(I0);
            2'd1:    lim = CW'(I1);
            default: lim = CW'(I2);
        endcase
    end

    always_comb begin
        r_d = r_q;
        if (hold || off || kick) begin
            r_d.cnt  = '0;
            r_d.bite = 1'b0;
        end else if (!r_q.bite && tick) begin
            if (r_q.cnt >= lim - CW'(1)) begin
                r_d.cnt  = '0;
                r_d.bite = 1'b1;
            end else begin
                r_d.cnt = r_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.cnt  <= '0;
            r_q.bite <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign bite = r_q.bite;

    a_r8_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !r_q.bite && r_q.cnt == '0);

    a_r6_bite_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.bite && !hold && !kick && !off |=> r_q.bite);

    a_r7_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !r_q.bite && r_q.cnt == '0);

    a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        off |=> !r_q.bite);

endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor
    import sup_pkg::*;
#(
    parameter int unsigned POR_T0 = 50,
    parameter int unsigned POR_T1 = 200,
    parameter int unsigned POR_T2 = 400,
    parameter int unsigned POR_T3 = 800,
    parameter int unsigned WDT_T0 = 25,
    parameter int unsigned WDT_T1 = 200,
    parameter int unsigned WDT_T2 = 1400
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               supply_ok,
    input  logic               aux_ok,
    input  logic               sda,
    input  logic               scl,
    input  logic [1:0]         por_sel,
    input  logic [1:0]         wdt_sel,
    input  logic               fault_clr,
    output logic               rst_hi,
    output logic               rst_lo_n,
    output logic               wdt_n,
    output logic               aux_fail_n,
    output logic [FAULT_W-1:0] fault_q
);

    logic por_act;
    logic kick;
    logic bite;

    sup_bus_watch u_bus (
        .clk   (clk),
        .rst_n (rst_n),
        .sda   (sda),
        .scl   (scl),
        .kick  (kick)
    );

    sup_por #(
        .T0 (POR_T0),
        .T1 (POR_T1),
        .T2 (POR_T2),
        .T3 (POR_T3)
    ) u_por (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .supply_ok (supply_ok),
        .sel       (por_sel),
        .active    (por_act)
    );

    sup_wdt #(
        .I0 (WDT_T0),
        .I1 (WDT_T1),
        .I2 (WDT_T2)
    ) u_wdt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .hold  (por_act),
        .kick  (kick),
        .sel   (wdt_sel),
        .bite  (bite)
    );

    logic [FAULT_W-1:0] flt_d, flt_q, flt_set;

    always_comb begin
        flt_set            = '0;
        flt_set[FB_SUPPLY] = ~supply_ok;
        flt_set[FB_AUX]    = ~aux_ok;
        flt_set[FB_WDT]    = bite;
        flt_d = (fault_clr ? '0 : flt_q) | flt_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flt_q <= '0;
        else        flt_q <= flt_d;
    end

    assign rst_hi     = por_act;
    assign rst_lo_n   = ~por_act;
    assign wdt_n      = ~bite;
    assign aux_fail_n = aux_ok;
    assign fault_q    = flt_q;

    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_clr |=> (flt_q & $past(flt_q)) == $past(flt_q));

    a_r10_supply_sets: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> flt_q[FB_SUPPLY]);

    a_r10_aux_sets: assert property (@(posedge clk) disable iff (!rst_n)
        !aux_ok |=> flt_q[FB_AUX]);

    a_r8_no_bite_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        rst_hi |=> wdt_n);

endmodule

// File: tb/supply_supervisor_bench.sv
`timescale 1ns/1ps
module supply_supervisor_bench;

    localparam int P0 = 4, P1 = 6, P2 = 9, P3 = 12;
    localparam int W0 = 8, W1 = 14, W2 = 20;

    typedef struct packed {
        logic [1:0] por_sel;
        logic [1:0] wdt_sel;
        logic [7:0] exp_por;
        logic [7:0] exp_wdt;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{2'd0, 2'd0, 8'(P0), 8'(W0)},
        '{2'd1, 2'd1, 8'(P1), 8'(W1)},
        '{2'd2, 2'd2, 8'(P2), 8'(W2)},
        '{2'd3, 2'd3, 8'(P3), 8'd0}
    };

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
    logic supply_ok = 1'b0, aux_ok = 1'b1, sda = 1'b1, scl = 1'b1;
    logic [1:0] por_sel = 2'd0, wdt_sel = 2'd3;
    logic fault_clr = 1'b0;
    logic rst_hi, rst_lo_n, wdt_n, aux_fail_n;
    logic [2:0] fault_q;

    int checks = 0, failures = 0;

    always #2 clk = ~clk;
    always @(negedge clk) tick <= ~tick;

    supply_supervisor #(
        .POR_T0(P0), .POR_T1(P1), .POR_T2(P2), .POR_T3(P3),
        .WDT_T0(W0), .WDT_T1(W1), .WDT_T2(W2)
    ) u_supply_supervisor (
        .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok),
        .aux_ok(aux_ok), .sda(sda), .scl(scl), .por_sel(por_sel),
        .wdt_sel(wdt_sel), .fault_clr(fault_clr), .rst_hi(rst_hi),
        .rst_lo_n(rst_lo_n), .wdt_n(wdt_n), .aux_fail_n(aux_fail_n),
        .fault_q(fault_q)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_step(input logic d, input logic c);
        sda = d; scl = c; cyc(4);
    endtask

    task automatic kick_full();
        bus_step(1, 1); bus_step(0, 1); bus_step(0, 0);
        bus_step(0, 1); bus_step(1, 1);
    endtask

    task automatic kick_bare();
        bus_step(1, 1); bus_step(0, 1); bus_step(1, 1);
    endtask

    task automatic wait_release(output int n);
        n = 0;
        while (rst_hi && n < 2000) begin @(negedge clk); n++; end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int n;
        cyc(3);
        // reset state
        chk(rst_hi == 1 && rst_lo_n == 0, "R4 reset state", rst_hi, 1);
        chk(wdt_n == 1 && fault_q == 0, "R8 reset state", {wdt_n, fault_q}, 8);
        aux_ok = 0; #1;
        chk(aux_fail_n == 0, "R9 in reset", aux_fail_n, 0);
        aux_ok = 1; #1;
        chk(aux_fail_n == 1, "R9 in reset", aux_fail_n, 1);
        @(negedge clk); rst_n = 1; cyc(2);

        foreach (VECS[k]) begin
            supply_ok = 0; cyc(3);
            chk(rst_hi == 1 && rst_lo_n == 0, "R1 supply low", rst_hi, 1);
            chk(wdt_n == 1, "R8 held in reset", wdt_n, 1);
            por_sel = VECS[k].por_sel; wdt_sel = VECS[k].wdt_sel;
            supply_ok = 1;
            wait_release(n);
            chk(n >= 2 * VECS[k].exp_por - 2 && n <= 2 * VECS[k].exp_por + 1,
                "R2 release time", n, 2 * VECS[k].exp_por);
            chk(rst_lo_n == 1, "R4 polarity after release", rst_lo_n, 1);
            if (VECS[k].exp_wdt == 0) begin
                cyc(2 * W2 + 10);
                chk(wdt_n == 1, "R5 disabled", wdt_n, 1);
            end else begin
                cyc(2 * VECS[k].exp_wdt - 3);
                chk(wdt_n == 1, "R5 before interval", wdt_n, 1);
                cyc(5);
                chk(wdt_n == 0, "R6 timeout", wdt_n, 0);
                cyc(20);
                chk(wdt_n == 0, "R6 stays asserted", wdt_n, 0);
                kick_full(); cyc(4);
                chk(wdt_n == 1, "R7 restart clears", wdt_n, 1);
            end
        end

        // R3: a one-cycle dip restarts the full timeout
        supply_ok = 0; por_sel = 2'd3; wdt_sel = 2'd3; cyc(3);
        supply_ok = 1; cyc(16);
        supply_ok = 0; cyc(1); supply_ok = 1;
        wait_release(n);
        chk(n >= 2 * P3 - 2 && n <= 2 * P3 + 1, "R3 dip restart", n, 2 * P3);

        // R7: bare start then stop does not restart
        supply_ok = 0; por_sel = 2'd0; wdt_sel = 2'd0; cyc(3);
        supply_ok = 1; wait_release(n);
        cyc(2 * W0 + 4);
        chk(wdt_n == 0, "R6 timeout again", wdt_n, 0);
        kick_bare(); cyc(4);
        chk(wdt_n == 0, "R7 bare stop ignored", wdt_n, 0);
        kick_full(); cyc(4);
        chk(wdt_n == 1, "R7 full pattern", wdt_n, 1);

        // R8: reset while timed out clears the watchdog output
        cyc(2 * W0 + 4);
        chk(wdt_n == 0, "R6 timeout third", wdt_n, 0);
        supply_ok = 0; cyc(2);
        chk(wdt_n == 1, "R8 reset clears", wdt_n, 1);

        // R6: regular restarts keep the watchdog quiet
        wdt_sel = 2'd1; supply_ok = 1; wait_release(n);
        for (int i = 0; i < 3; i++) begin
            kick_full();
            chk(wdt_n == 1, "R6 kept alive", wdt_n, 1);
        end

        // R10: sticky faults and clear
        wdt_sel = 2'd3; cyc(2);
        chk(fault_q == 3'b101, "R10 accumulated", fault_q, 5);
        fault_clr = 1; cyc(1); fault_clr = 0; cyc(1);
        chk(fault_q == 3'b000, "R10 cleared", fault_q, 0);
        aux_ok = 0; #1;
        chk(aux_fail_n == 0, "R9 follows", aux_fail_n, 0);
        cyc(1); aux_ok = 1; cyc(3);
        chk(fault_q == 3'b010, "R10 aux sticky", fault_q, 2);
        aux_ok = 0; fault_clr = 1; cyc(1); aux_ok = 1; fault_clr = 0; cyc(1);
        chk(fault_q == 3'b010, "R10 set wins over clear", fault_q, 2);
        fault_clr = 1; cyc(1); fault_clr = 0; cyc(1);
        chk(fault_q == 3'b000, "R10 cleared again", fault_q, 0);

        finish_run();
    end

endmodule